// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a word of digital inputs and raises one interrupt line when selected inputs change in a chosen way. The host reads the synchronised inputs directly through a small register port. All inputs can be read, but only the low channels can request an interrupt. Two channel masks give the trigger condition. In edge mode, the first mask picks channels that fire on a rising edge and the second picks channels that fire on a falling edge, and any single match fires. In level mode, the first mask names channels that must be high and the second names channels that must be low, and the block fires once when all of them hold together.

Triggers set bits in a sticky status word. Reading that word clears it. The interrupt line is the OR of the pending status bits, gated by an enable bit in the control word. Word addresses are: 0 raw inputs, 1 high/rising mask, 2 low/falling mask, 3 status, 4 control. The port is word addressed, with separate write and read strobes, and its read data is combinational from the address.

Top module: `cos_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, both masks, the control word and the status word read zero and `irq` is low.
- R2: A read at address 0 returns all NUM_IN inputs after a two-flop synchroniser. A change on `din` just before clock edge n reads back after edge n+1.
- R3: Addresses 1 and 2 store the low NUM_IRQ bits of `wdata` and read them back, with the upper bits reading zero. Writes to addresses 0 and 3 change nothing.
- R4: Control at address 4: bit 1 selects the mode (0 = edge/any, 1 = level/all) and bit 2 is the interrupt enable. Every other control bit reads zero.
- R5: In edge mode, channel i sets status bit i when mask-1 bit i is set and the input rises, or when mask-2 bit i is set and the input falls. A `din` change just before edge n shows in status after edge n+2.
- R6: In level mode, when every mask-1 channel is high, every mask-2 channel is low and at least one channel is selected, the status word gains the OR of both masks.
- R7: In level mode, a satisfied condition fires only once. It fires again only after the condition has gone false and then become true again.
- R8: In level mode with both masks zero, nothing ever triggers.
- R9: A read strobe at address 3 returns the current status and clears it at that edge. A trigger in the same cycle stays set. Without a read, status bits stay set.
- R10: `irq` is high exactly when enable is set and status is non-zero. Clearing the enable masks `irq` but keeps the masks, the mode and any latched status. Setting the enable again resumes normal operation.
- R11: Inputs at or above NUM_IRQ never set a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NUM_IN | Asynchronous digital inputs |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears status when address is 3) |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that a detected trigger lands in status, that status bits persist until a read, and that a read with no new trigger leaves status empty. They also check that level mode never fires twice in a row without a write, that level mode with empty masks never fires, and that `irq` never rises without a pending bit. Only the bench scenarios can show the pipeline latency from `din` to status, the rising/falling selection per mask and the re-arm after the level condition drops. The same holds for a trigger surviving a read in its own cycle and for configuration surviving an enable toggle. A behavioural model compares `irq` and the read data each cycle.

// File: rtl/cos_irq_ctrl.sv
`timescale 1ns/1ps
module cos_irq_ctrl #(
  parameter int NUM_IN  = 32,
  parameter int NUM_IRQ = 16,
  parameter int DW      = 32,
  parameter int AW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] din,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  localparam logic [AW-1:0] A_RAW  = AW'(0);
  localparam logic [AW-1:0] A_MHI  = AW'(1);
  localparam logic [AW-1:0] A_MLO  = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [AW-1:0] A_CTRL = AW'(4);
  localparam int MODE_BIT = 1;
  localparam int EN_BIT   = 2;

  logic [NUM_IN-1:0]  sync1, sync2;
  logic [NUM_IRQ-1:0] prev, mask_hi, mask_lo, status, hit;
  logic               mode_lvl, irq_en, cond_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      prev  <= sync2[NUM_IRQ-1:0];
    end

  wire [NUM_IRQ-1:0] cur  = sync2[NUM_IRQ-1:0];
  wire [NUM_IRQ-1:0] sel  = mask_hi | mask_lo;
  wire               cond = (|sel) && ((cur & mask_hi) == mask_hi) && ((~cur & mask_lo) == mask_lo);

  assign hit = mode_lvl ? ((cond && !cond_q) ? sel : '0)
                        : ((cur & ~prev & mask_hi) | (~cur & prev & mask_lo));

  wire stat_rd = rd_en && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_hi  <= '0;
      mask_lo  <= '0;
      mode_lvl <= 1'b0;
      irq_en   <= 1'b0;
      cond_q   <= 1'b0;
      status   <= '0;
    end else begin
      cond_q <= cond;
      status <= (stat_rd ? '0 : status) | hit;
      if (wr_en)
        case (addr)
          A_MHI:  mask_hi <= wdata[NUM_IRQ-1:0];
          A_MLO:  mask_lo <= wdata[NUM_IRQ-1:0];
          A_CTRL: begin
            mode_lvl <= wdata[MODE_BIT];
            irq_en   <= wdata[EN_BIT];
          end
          default: ;
        endcase
    end

  always_comb begin
    rdata = '0;
    case (addr)
      A_RAW:  rdata[NUM_IN-1:0]  = sync2;
      A_MHI:  rdata[NUM_IRQ-1:0] = mask_hi;
      A_MLO:  rdata[NUM_IRQ-1:0] = mask_lo;
      A_STAT: rdata[NUM_IRQ-1:0] = status;
      A_CTRL: begin
        rdata[MODE_BIT] = mode_lvl;
        rdata[EN_BIT]   = irq_en;
      end
      default: ;
    endcase
  end

  assign irq = irq_en & (|status);

  wire unused_wdata = &{1'b0, wdata[DW-1:NUM_IRQ]};
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
`timescale 1ns/1ps
module cos_irq_ctrl_chk #(
  parameter int NUM_IRQ = 16,
  parameter int AW      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [AW-1:0]      addr,
  input logic               irq,
  input logic               mode_lvl,
  input logic [NUM_IRQ-1:0] hit,
  input logic [NUM_IRQ-1:0] status,
  input logic [NUM_IRQ-1:0] mask_hi,
  input logic [NUM_IRQ-1:0] mask_lo
);
  wire rd_stat = rd_en && (addr == AW'(3));

  assert_trigger_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((status & $past(status)) == $past(status)));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && hit == '0) |=> (status == '0));

  assert_level_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lvl && hit != '0 && !wr_en) |=> (hit == '0));

  assert_empty_and_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lvl && mask_hi == '0 && mask_lo == '0) |-> (hit == '0));

  assert_irq_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .irq(irq), .mode_lvl(mode_lvl), .hit(hit), .status(status),
  .mask_hi(mask_hi), .mask_lo(mask_lo)
);

// File: tb/tb_cos_irq_ctrl.sv
`timescale 1ns/1ps
module tb_cos_irq_ctrl;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq;
  logic [31:0] din = 0, wdata = 0, rdata, rv;
  logic [2:0]  addr = 0;
  int checks = 0, errors = 0;

  cos_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .rd_en(rd_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  logic [31:0] hist[$];
  logic [15:0] m_hi, m_lo, m_stat;
  logic        m_lvl, m_en, m_cp;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {32'h0, 32'h0, 32'h0};
      m_hi = 0; m_lo = 0; m_stat = 0; m_lvl = 0; m_en = 0; m_cp = 0;
    end else begin
      logic [15:0] now_v, was_v, h;
      logic        c;
      now_v = hist[1][15:0];
      was_v = hist[2][15:0];
      c = ((m_hi | m_lo) != 0) && ((now_v & m_hi) == m_hi) && ((~now_v & m_lo) == m_lo);
      if (m_lvl) h = (c && !m_cp) ? (m_hi | m_lo) : 16'h0;
      else       h = (now_v & ~was_v & m_hi) | (~now_v & was_v & m_lo);
      m_cp = c;
      if (rd_en && addr == 3) m_stat = 0;
      m_stat = m_stat | h;
      if (wr_en) begin
        if (addr == 1) m_hi = wdata[15:0];
        if (addr == 2) m_lo = wdata[15:0];
        if (addr == 4) begin m_lvl = wdata[1]; m_en = wdata[2]; end
      end
      hist.push_front(din);
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [31:0] e;
      string t;
      case (addr)
        3'd0: begin e = hist[1];                t = "R2 raw model"; end
        3'd1: begin e = {16'h0, m_hi};          t = "R3 mask1 model"; end
        3'd2: begin e = {16'h0, m_lo};          t = "R3 mask2 model"; end
        3'd3: begin e = {16'h0, m_stat};        t = "R9 status model"; end
        3'd4: begin e = {29'h0, m_en, m_lvl, 1'b0}; t = "R4 ctrl model"; end
        default: begin e = 0;                   t = "R3 unmapped model"; end
      endcase
      check(t, rdata, e);
      check("R10 irq model", {31'h0, irq}, {31'h0, m_en && m_stat != 0});
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0; addr = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    check("R1 irq in reset", {31'h0, irq}, 0);
    rst_n = 1;
    rd(3, rv); check("R1 status after reset", rv, 0);
    rd(4, rv); check("R1 ctrl after reset", rv, 0);
    rd(1, rv); check("R1 mask1 after reset", rv, 0);
    check("R1 irq after reset", {31'h0, irq}, 0);

    din = 32'hA5A5_C3C3; tick(3);
    rd(0, rv); check("R2 raw inputs", rv, 32'hA5A5_C3C3);
    din = 0; tick(4);

    wr(1, 32'hFFFF_00F0); rd(1, rv); check("R3 mask1 readback", rv, 32'h0000_00F0);
    wr(0, 32'h1234_5678); wr(3, 32'hFFFF_FFFF);
    rd(3, rv); check("R3 status write ignored", rv, 0);
    wr(4, 32'hFFFF_FFFF); rd(4, rv); check("R4 ctrl bits", rv, 32'h6);
    wr(4, 0);

    wr(1, 32'h1); wr(2, 32'h2); wr(4, 32'h4);
    din = 32'h1; tick(4);
    check("R5 irq on rising edge", {31'h0, irq}, 1);
    rd(3, rv); check("R5 rising status", rv, 32'h1);
    rd(3, rv); check("R9 cleared by read", rv, 0);
    check("R10 irq drops after clear", {31'h0, irq}, 0);
    din = 32'h3; tick(4);
    rd(3, rv); check("R5 rise on fall-only channel", rv, 0);
    din = 32'h1; tick(4);
    rd(3, rv); check("R5 falling status", rv, 32'h2);

    din = 32'hFFFF_0001; tick(4);
    rd(3, rv); check("R11 upper inputs", rv, 0);
    din = 32'h1; tick(4);

    wr(4, 0); din = 0; tick(4); din = 32'h1; tick(4);
    check("R10 irq masked", {31'h0, irq}, 0);
    rd(1, rv); check("R10 mask kept", rv, 32'h1);
    wr(4, 32'h4);
    check("R10 irq resumes", {31'h0, irq}, 1);
    rd(3, rv); check("R10 status kept", rv, 32'h1);

    din = 0; tick(4);
    wr(1, 32'h10); wr(2, 32'h20); wr(4, 32'h6); tick(2);
    din = 32'h10; tick(4);
    check("R6 level irq", {31'h0, irq}, 1);
    rd(3, rv); check("R6 level status", rv, 32'h30);
    tick(6);
    rd(3, rv); check("R7 no refire while held", rv, 0);
    din = 32'h30; tick(4);
    din = 32'h10; tick(4);
    rd(3, rv); check("R7 rearm after drop", rv, 32'h30);

    wr(1, 0); wr(2, 0); tick(2);
    din = 0; tick(4); din = 32'h10; tick(4);
    rd(3, rv); check("R8 empty masks", rv, 0);

    wr(1, 32'h1); wr(4, 32'h4); din = 0; tick(4);
    rd(3, rv);
    @(negedge clk); din = 32'h1;
    @(negedge clk);
    @(negedge clk); rd_en = 1; addr = 3; #1 rv = rdata;
    check("R9 read before same-cycle trigger", rv, 0);
    @(negedge clk); rd_en = 0; addr = 0;
    rd(3, rv); check("R9 same-cycle trigger kept", rv, 32'h1);

    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule